// File: doc/BRIEF.md
# DDR Training Sequencer

This block walks a DDR memory controller through its complete training flow. It does this by issuing single register accesses on a simple valid/ready master port with 32-bit address and data. When `start` is pulsed, the sequencer saves the settings it is about to override. It zeroes the power-down timer field, stops auto refresh and sends one refresh command. It waits for the controller to grant the connection, then disables the chip select that is not under calibration.

Three hardware calibration phases then run in a fixed order: read strobe gating, read delay and write delay. Each phase starts with two read-FIFO resets and a precharge-all for every chip select still enabled. The sequencer polls each phase's self-clearing enable bit and counts the error flags. After gating, it replaces the gating offsets with values derived from the upper window bound. The second PHY is accessed only on a 64-bit bus.

Finally, every saved setting is restored and `done` rises with an error count. If any poll goes `poll_limit` consecutive reads without meeting its condition, the flow stops at once with `timed_out` set.

Register offsets from `BASE` are: control 0x00, power-down timer 0x04, misc 0x08, refresh 0x0C, command 0x10, gating control 0/1 0x20/0x24, gating status 0..3 0x30..0x3C, read-delay hardware control 0x40 and write-delay hardware control 0x44. The second PHY sits at `BASE + PHY1_OFS`.

Top module: `ddr_train_seq`

## Requirements
- R1: After reset `busy`, `done`, `timed_out` and `req_valid` are 0 and `err_count` is 0.
- R2: A request holds `req_valid`, `req_addr`, `req_write` and `req_wdata` stable until `req_ready`. No request is made while `busy` is 0.
- R3: The refresh register is saved, then written with 0x0000C000, and the saved value is written back at the end.
- R4: Bits 15:8 of the power-down register are cleared at the start. At the end, 0x5500 is ORed into the register; other bits are kept.
- R5: One refresh command is issued per chip select enabled at start: 0x00008020 for CS0 (control bit 31) and 0x00008028 for CS1 (control bit 30). The sequencer then polls until command bit 14 reads 1. At the end it writes 0 to the command register and polls until bit 14 reads 0.
- R6: Misc bit 20 = 0 targets CS0, so control bit 30 is cleared; 1 targets CS1, so bit 31 is cleared. The original chip-select bits are restored at the end.
- R7: Before each of the three phases, a precharge-all is written for each enabled chip select: 0x04008050 for CS0 and 0x04008058 for CS1.
- R8: Before each phase, the read FIFOs are reset twice. Each reset sets bit 31 of gating control 0 and polls until it reads 0.
- R9: Gating sets bit 30 of gating control 0, then also sets bit 28. It polls until bit 28 is 0, and bit 12 set counts one error.
- R10: Read delay and write delay each write 0x30 to their hardware-control register and poll until bit 4 is 0. Any of bits 3:0 set counts one error.
- R11: When control bits 17:16 equal 2, the second PHY's gating flag (bit 12) and delay flags (bits 3:0) are also read and counted, and its gating results are rewritten. Otherwise the second PHY is never written and its flags are ignored.
- R12: For each gating control register, each of its two lanes comes from one status register: lane 0 from status bits 26:16 of the first, lane 1 from the second. For each lane, t = u − 0xC0 modulo 2^11. The lane field is t[6:0] at bits 6:0 and t[10:7] at bits 11:8. Lane 1 sits 16 bits higher, bits 31:28 are kept and all other bits are 0.
- R13: A poll that reads its condition unmet `poll_limit` times in a row ends the flow. `done` and `timed_out` are set and no further access is issued.
- R14: `done` and `err_count` hold until the next `start`. `err_count` changes only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (when idle or done) |
| poll_limit | input | POLL_W | Consecutive unmet poll reads that abort the flow |
| req_valid | output | 1 | Register access request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Access address |
| req_wdata | output | 32 | Write data |
| req_ready | input | 1 | Access accepted this cycle |
| rsp_rdata | input | 32 | Read data, valid in the accept cycle |
| busy | output | 1 | Flow running |
| done | output | 1 | Flow finished (normally or by timeout) |
| timed_out | output | 1 | Flow ended by a poll timeout |
| err_count | output | ERR_W | Number of error flags seen |

## Verification
A wrong step index or a wrong skip condition in the sequencer shows directly in the register model. A precharge count, a chip-select value or a PHY-1 write count comes out different by the end of the same run. A corrupted saved value shows only when the restore steps run at the end of the flow, as a wrong final refresh, power-down or control register. A poll counter that counts wrongly moves the timeout by a read or more, so the read count of gating control 0 at the limit-2, limit-3 and limit-5 boundaries exposes it within one flow.

// File: rtl/ddr_train_seq.sv
module ddr_train_seq #(
  parameter logic [31:0] BASE     = 32'h0,
  parameter logic [31:0] PHY1_OFS = 32'h4000,
  parameter int          POLL_W   = 16,
  parameter int          ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              req_valid,
  output logic              req_write,
  output logic [31:0]       req_addr,
  output logic [31:0]       req_wdata,
  input  logic              req_ready,
  input  logic [31:0]       rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic [ERR_W-1:0]  err_count
);
  localparam logic [7:0] O_CTRL = 8'h00, O_PDT = 8'h04, O_MISC = 8'h08, O_REF = 8'h0C,
                         O_CMD = 8'h10, O_GC0 = 8'h20, O_GC1 = 8'h24,
                         O_ST0 = 8'h30, O_ST1 = 8'h34, O_ST2 = 8'h38, O_ST3 = 8'h3C,
                         O_RDHW = 8'h40, O_WRHW = 8'h44;
  localparam logic [31:0] B31 = 32'h8000_0000, B30 = 32'h4000_0000, B28 = 32'h1000_0000,
                          B14 = 32'h0000_4000, B12 = 32'h0000_1000, B4 = 32'h10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;
  logic [2:0]  phase;
  logic [4:0]  sub, last_sub, k;
  logic [31:0] acc, ctrl_sv, ref_sv;
  logic        tgt;
  logic [11:0] lane_lo, lane_hi;
  logic [POLL_W-1:0] pcnt;

  logic        s_wr, s_phy1, s_skip;
  logic [7:0]  s_ofs;
  logic [31:0] s_wd, s_pmask, s_pval, s_emask;

  wire cs0_init = ctrl_sv[31];
  wire cs1_init = ctrl_sv[30];
  wire cs0_cur  = cs0_init & ~tgt;
  wire cs1_cur  = cs1_init & tgt;
  wire wide     = (ctrl_sv[17:16] == 2'd2);

  function automatic logic [11:0] lane_of(input logic [10:0] u);
    logic [10:0] t;
    t = u - 11'h0C0;
    return {t[10:7], 1'b0, t[6:0]};
  endfunction

  assign k = sub - 5'd13;

  always_comb begin
    s_wr = 1'b0; s_phy1 = 1'b0; s_skip = 1'b0; s_ofs = O_CTRL; s_wd = '0;
    s_pmask = '0; s_pval = '0; s_emask = '0; last_sub = 5'd0;
    case (phase)
      3'd0: begin
        last_sub = 5'd9;
        case (sub)
          5'd1: s_ofs = O_PDT;
          5'd2: begin s_wr = 1'b1; s_ofs = O_PDT; s_wd = acc & ~32'h0000_FF00; end
          5'd3: s_ofs = O_REF;
          5'd4: begin s_wr = 1'b1; s_ofs = O_REF; s_wd = 32'h0000_C000; end
          5'd5: begin s_wr = 1'b1; s_ofs = O_CMD; s_wd = 32'h0000_8020; s_skip = ~cs0_init; end
          5'd6: begin s_wr = 1'b1; s_ofs = O_CMD; s_wd = 32'h0000_8028; s_skip = ~cs1_init; end
          5'd7: begin s_ofs = O_CMD; s_pmask = B14; s_pval = B14; end
          5'd8: s_ofs = O_MISC;
          5'd9: begin s_wr = 1'b1; s_wd = tgt ? (ctrl_sv & ~B31) : (ctrl_sv & ~B30); end
          default: ;
        endcase
      end
      3'd1, 3'd2, 3'd3: begin
        last_sub = (phase == 3'd1) ? 5'd28 : 5'd10;
        if (sub < 5'd8) begin
          case (sub)
            5'd0, 5'd3: s_ofs = O_GC0;
            5'd1, 5'd4: begin s_wr = 1'b1; s_ofs = O_GC0; s_wd = acc | B31; end
            5'd2, 5'd5: begin s_ofs = O_GC0; s_pmask = B31; end
            5'd6: begin s_wr = 1'b1; s_ofs = O_CMD; s_wd = 32'h0400_8050; s_skip = ~cs0_cur; end
            default: begin s_wr = 1'b1; s_ofs = O_CMD; s_wd = 32'h0400_8058; s_skip = ~cs1_cur; end
          endcase
        end else if (phase == 3'd1) begin
          case (sub)
            5'd8:  s_ofs = O_GC0;
            5'd9:  begin s_wr = 1'b1; s_ofs = O_GC0; s_wd = acc | B30; end
            5'd10: begin s_wr = 1'b1; s_ofs = O_GC0; s_wd = acc | B30 | B28; end
            5'd11: begin s_ofs = O_GC0; s_pmask = B28; s_emask = B12; end
            5'd12: begin s_ofs = O_GC0; s_phy1 = 1'b1; s_emask = B12; s_skip = ~wide; end
            default: begin
              s_phy1 = k[3];
              s_skip = k[3] & ~wide;
              case (k[1:0])
                2'd0: s_ofs = k[2] ? O_ST2 : O_ST0;
                2'd1: s_ofs = k[2] ? O_ST3 : O_ST1;
                2'd2: s_ofs = k[2] ? O_GC1 : O_GC0;
                default: begin
                  s_wr = 1'b1; s_ofs = k[2] ? O_GC1 : O_GC0;
                  s_wd = {acc[31:28], lane_hi, 4'h0, lane_lo};
                end
              endcase
            end
          endcase
        end else begin
          s_ofs = (phase == 3'd2) ? O_RDHW : O_WRHW;
          case (sub)
            5'd8: begin s_wr = 1'b1; s_wd = 32'h30; end
            5'd9: begin s_pmask = B4; s_emask = 32'hF; end
            default: begin s_phy1 = 1'b1; s_emask = 32'hF; s_skip = ~wide; end
          endcase
        end
      end
      default: begin
        last_sub = 5'd6;
        case (sub)
          5'd0: s_ofs = O_PDT;
          5'd1: begin s_wr = 1'b1; s_ofs = O_PDT; s_wd = acc | 32'h0000_5500; end
          5'd2: s_ofs = O_CTRL;
          5'd3: begin s_wr = 1'b1; s_wd = acc | {ctrl_sv[31:30], 30'h0}; end
          5'd4: begin s_wr = 1'b1; s_ofs = O_REF; s_wd = ref_sv; end
          5'd5: begin s_wr = 1'b1; s_ofs = O_CMD; s_wd = 32'h0; end
          default: begin s_ofs = O_CMD; s_pmask = B14; end
        endcase
      end
    endcase
  end

  assign busy      = (st == S_RUN);
  assign done      = (st == S_FIN);
  assign req_valid = busy & ~s_skip;
  assign req_write = s_wr;
  assign req_wdata = s_wd;
  assign req_addr  = BASE + (s_phy1 ? PHY1_OFS : 32'h0) + {24'h0, s_ofs};

  wire hs      = req_valid & req_ready;
  wire hit     = ((rsp_rdata & s_pmask) == s_pval);
  wire advance = busy & (s_skip | (hs & (s_wr | hit)));
  wire [POLL_W:0] miss_n = {1'b0, pcnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= '0; sub <= '0; acc <= '0; ctrl_sv <= '0; ref_sv <= '0;
      tgt <= 1'b0; lane_lo <= '0; lane_hi <= '0; pcnt <= '0; timed_out <= 1'b0; err_count <= '0;
    end else if (!busy) begin
      if (start) begin
        st <= S_RUN; phase <= '0; sub <= '0; pcnt <= '0; timed_out <= 1'b0; err_count <= '0;
      end
    end else if (advance) begin
      pcnt <= '0;
      if (sub == last_sub) begin
        sub <= '0;
        if (phase == 3'd4) st <= S_FIN;
        else phase <= phase + 3'd1;
      end else begin
        sub <= sub + 5'd1;
      end
      if (!s_skip && !s_wr) begin
        acc <= rsp_rdata;
        if ((rsp_rdata & s_emask) != 32'h0) err_count <= err_count + 1'b1;
        if (phase == 3'd0 && sub == 5'd0) ctrl_sv <= rsp_rdata;
        if (phase == 3'd0 && sub == 5'd3) ref_sv <= rsp_rdata;
        if (phase == 3'd0 && sub == 5'd8) tgt <= rsp_rdata[20];
        if (phase == 3'd1 && sub >= 5'd13 && k[1:0] == 2'd0) lane_lo <= lane_of(rsp_rdata[26:16]);
        if (phase == 3'd1 && sub >= 5'd13 && k[1:0] == 2'd1) lane_hi <= lane_of(rsp_rdata[26:16]);
      end
    end else if (hs) begin
      if (miss_n >= {1'b0, poll_limit}) begin
        st <= S_FIN; timed_out <= 1'b1;
      end else begin
        pcnt <= miss_n[POLL_W-1:0];
      end
    end
  end
endmodule

module ddr_train_seq_chk #(
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             timed_out,
  input logic [ERR_W-1:0] err_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic [31:0]      req_wdata
);
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
  a_r13_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (done && !busy));
  a_r14_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r14_err_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_count));
  a_r9_err_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));
endmodule

bind ddr_train_seq ddr_train_seq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timed_out(timed_out), .err_count(err_count), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata)
);

// File: tb/tb_ddr_train_seq.sv
`timescale 1ns/1ps
module tb_ddr_train_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] poll_limit = 16'd50;
  logic req_valid, req_write, req_ready, busy, done, timed_out;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic [3:0] err_count;
  always #2.5 clk = ~clk;

  ddr_train_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
    .timed_out(timed_out), .err_count(err_count));

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // configuration for the register model
  logic cfg_clr = 1'b0;
  int   cfg_run, cfg_cs, cfg_tgt;
  bit   cfg_wide, cfg_hang;
  bit   g0, g1;
  logic [3:0] r0p, r1p, w0p, w1p;

  function automatic int uval(input int r, input int p, input int i);
    if (r == 0) begin
      case (p * 4 + i)
        0: return 'h000; 1: return 'h0C0; 2: return 'h7FF; 3: return 'h0BF;
        4: return 'h100; 5: return 'h13F; 6: return 'h140; default: return 'h400;
      endcase
    end
    return (r * 197 + p * 61 + i * 37 + 11) & 'h7FF;
  endfunction
  function automatic int lane_exp(input int u);
    int t;
    t = (u - 'hC0) & 'h7FF;
    return (t & 'h7F) | ((t >> 7) << 8);
  endfunction

  logic [31:0] mem0 [0:31];
  logic [31:0] mem1 [0:31];
  logic rdy;
  int c31, c28, crd, cwr;
  int n_ref20, n_ref28, n_pre0, n_pre1, n_fifo, n_phy1_wr, n_gc0_rd, n_acc;
  bit ref_c000, pd_seen, ctrl_seen;
  logic [31:0] pd_mid, ctrl_mid;
  logic [31:0] v;
  int ix;

  assign req_ready = rdy;
  assign rsp_rdata = req_addr[14] ? mem1[req_addr[6:2]] : mem0[req_addr[6:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b0;
    end else if (cfg_clr) begin
      rdy <= 1'b0;
      for (int i = 0; i < 32; i++) begin mem0[i] <= '0; mem1[i] <= '0; end
      mem0[0] <= (32'(cfg_cs) << 30) | ((cfg_wide ? 32'd2 : 32'd1) << 16) | 32'h123;
      mem0[2] <= (32'(cfg_tgt) << 20) | 32'h7;
      mem0[1] <= 32'h1234_ABCD;
      mem0[3] <= 32'h0000_0123;
      mem0[8] <= 32'h2000_0ABC; mem1[8] <= 32'h2000_0ABC;
      mem0[9] <= 32'h3000_1234; mem1[9] <= 32'h3000_1234;
      for (int i = 0; i < 4; i++) begin
        mem0[12+i] <= {5'b0, 11'(uval(cfg_run, 0, i)), 16'h0055};
        mem1[12+i] <= {5'b0, 11'(uval(cfg_run, 1, i)), 16'h0055};
      end
      c31 <= 0; c28 <= 0; crd <= 0; cwr <= 0;
      n_ref20 <= 0; n_ref28 <= 0; n_pre0 <= 0; n_pre1 <= 0; n_fifo <= 0;
      n_phy1_wr <= 0; n_gc0_rd <= 0; n_acc <= 0;
      ref_c000 <= 1'b0; pd_seen <= 1'b0; ctrl_seen <= 1'b0; pd_mid <= '0; ctrl_mid <= '0;
    end else if (rdy) begin
      rdy <= 1'b0;
      n_acc <= n_acc + 1;
      ix = int'(req_addr[6:2]);
      if (req_write) begin
        if (req_addr[14]) begin
          n_phy1_wr <= n_phy1_wr + 1;
          mem1[ix] <= req_wdata;
        end else begin
          case (ix)
            4: begin
              mem0[4] <= req_wdata[15] ? (req_wdata | 32'h4000) : (req_wdata & ~32'h4000);
              if (req_wdata == 32'h0000_8020) n_ref20 <= n_ref20 + 1;
              if (req_wdata == 32'h0000_8028) n_ref28 <= n_ref28 + 1;
              if (req_wdata == 32'h0400_8050) n_pre0 <= n_pre0 + 1;
              if (req_wdata == 32'h0400_8058) n_pre1 <= n_pre1 + 1;
            end
            8: begin
              v = req_wdata;
              if (v[31]) begin n_fifo <= n_fifo + 1; c31 <= 2; end
              if (v[28]) begin
                c28 <= 2;
                v = v | (32'(g0) << 12);
                mem1[8] <= mem1[8] | (32'(g1) << 12);
              end
              mem0[8] <= v;
            end
            16: begin mem0[16] <= req_wdata | 32'(r0p); mem1[16] <= mem1[16] | 32'(r1p); crd <= 2; end
            17: begin mem0[17] <= req_wdata | 32'(w0p); mem1[17] <= mem1[17] | 32'(w1p); cwr <= 2; end
            default: begin
              mem0[ix] <= req_wdata;
              if (ix == 3 && req_wdata == 32'h0000_C000) ref_c000 <= 1'b1;
              if (ix == 1 && !pd_seen) begin pd_seen <= 1'b1; pd_mid <= req_wdata; end
              if (ix == 0 && !ctrl_seen) begin ctrl_seen <= 1'b1; ctrl_mid <= req_wdata; end
            end
          endcase
        end
      end else if (!req_addr[14]) begin
        if (ix == 8) begin
          n_gc0_rd <= n_gc0_rd + 1;
          if (c31 != 0) begin
            c31 <= c31 - 1;
            if (c31 == 1) mem0[8] <= mem0[8] & ~32'h8000_0000;
          end else if (c28 != 0 && !cfg_hang) begin
            c28 <= c28 - 1;
            if (c28 == 1) mem0[8] <= mem0[8] & ~32'h1000_0000;
          end
        end
        if (ix == 16 && crd != 0) begin crd <= crd - 1; if (crd == 1) mem0[16] <= mem0[16] & ~32'h10; end
        if (ix == 17 && cwr != 0) begin cwr <= cwr - 1; if (cwr == 1) mem0[17] <= mem0[17] & ~32'h10; end
      end
    end else if (req_valid) begin
      rdy <= 1'b1;
    end
  end

  // R2 handshake monitor
  int  viol = 0;
  logic pv = 1'b0, pr = 1'b0;
  logic [31:0] pa, pw;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr && (!req_valid || req_addr != pa || req_wdata != pw)) viol++;
      if (req_valid && !busy) viol++;
    end
    pv = req_valid; pr = rdy; pa = req_addr; pw = req_wdata;
  end

  task automatic run_flow(input int r, input int cs, input int tgt, input bit wide,
                          input bit hang, input int lim);
    int n;
    bit [5:0] e;
    cfg_run = r; cfg_cs = cs; cfg_tgt = tgt; cfg_wide = wide; cfg_hang = hang;
    e = 6'((r * 11 + 3) & 63);
    g0 = e[0]; g1 = e[1];
    r0p = e[2] ? (4'h1 << (r % 4)) : 4'h0;
    r1p = e[3] ? (4'h1 << ((r + 1) % 4)) : 4'h0;
    w0p = e[4] ? (4'h1 << ((r + 2) % 4)) : 4'h0;
    w1p = e[5] ? (4'h1 << ((r + 3) % 4)) : 4'h0;
    poll_limit = 16'(lim);
    @(negedge clk); cfg_clr = 1'b1;
    @(negedge clk); cfg_clr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic check_normal(input int r, input int cs, input int tgt, input bit wide);
    int c0, c1, ee, gexp0, gexp1, hexp0, hexp1;
    logic [31:0] ctrl0;
    c0 = (cs >> 1) & 1; c1 = cs & 1;
    ctrl0 = (32'(cs) << 30) | ((wide ? 32'd2 : 32'd1) << 16) | 32'h123;
    ee = int'(g0) + int'(r0p != 0) + int'(w0p != 0);
    if (wide) ee += int'(g1) + int'(r1p != 0) + int'(w1p != 0);
    chk(done && !timed_out && !busy, "R13 normal completion", {done, timed_out}, 2'b10);
    chk(err_count == 4'(ee), "R9 R10 R11 error count", err_count, ee);
    chk(ref_c000 && mem0[3] == 32'h123, "R3 refresh stop and restore", mem0[3], 32'h123);
    chk(pd_mid == 32'h1234_00CD, "R4 power-down field cleared", pd_mid, 32'h1234_00CD);
    chk(mem0[1] == 32'h1234_55CD, "R4 power-down field re-enabled", mem0[1], 32'h1234_55CD);
    chk(n_ref20 == c0 && n_ref28 == c1, "R5 refresh per chip select", {n_ref20, n_ref28}, {c0, c1});
    chk(mem0[4] == 32'h0, "R5 command register cleared", mem0[4], 0);
    chk(ctrl_mid == (tgt ? ctrl0 & ~32'h8000_0000 : ctrl0 & ~32'h4000_0000),
        "R6 non-target chip select disabled", ctrl_mid, tgt);
    chk(mem0[0] == ctrl0, "R6 chip selects restored", mem0[0], ctrl0);
    chk(n_pre0 == 3 * (c0 & ~tgt & 1) && n_pre1 == 3 * (c1 & tgt),
        "R7 precharge per phase", {n_pre0, n_pre1}, {3 * (c0 & ~tgt & 1), 3 * (c1 & tgt)});
    chk(n_fifo == 6, "R8 two FIFO resets per phase", n_fifo, 6);
    gexp0 = 'h6000_0000 | (lane_exp(uval(r, 0, 1)) << 16) | lane_exp(uval(r, 0, 0));
    gexp1 = 'h3000_0000 | (lane_exp(uval(r, 0, 3)) << 16) | lane_exp(uval(r, 0, 2));
    chk(mem0[8] == 32'(gexp0), "R12 R9 gating result lane pair 0", mem0[8], gexp0);
    chk(mem0[9] == 32'(gexp1), "R12 gating result lane pair 1", mem0[9], gexp1);
    if (wide) begin
      hexp0 = 'h2000_0000 | (lane_exp(uval(r, 1, 1)) << 16) | lane_exp(uval(r, 1, 0));
      hexp1 = 'h3000_0000 | (lane_exp(uval(r, 1, 3)) << 16) | lane_exp(uval(r, 1, 2));
      chk(mem1[8] == 32'(hexp0) && mem1[9] == 32'(hexp1), "R11 R12 second PHY rewritten",
          mem1[8], hexp0);
      chk(n_phy1_wr == 2, "R11 second PHY writes in wide mode", n_phy1_wr, 2);
    end else begin
      chk(n_phy1_wr == 0, "R11 second PHY untouched in narrow mode", n_phy1_wr, 0);
      chk(mem1[8] == (32'h2000_0ABC | (32'(g1) << 12)) && mem1[9] == 32'h3000_1234,
          "R11 second PHY gating registers unchanged", mem1[8], 32'h2000_0ABC);
    end
  endtask

  initial begin
    int r, a0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timed_out && !req_valid && err_count == 0, "R1 reset state",
        {busy, done, timed_out, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid && err_count == 0, "R1 idle after reset", {busy, done}, 0);
    r = 0;
    for (int cs = 1; cs < 4; cs++)
      for (int tgt = 0; tgt < 2; tgt++)
        for (int w = 0; w < 2; w++) begin
          run_flow(r, cs, tgt, w[0], 1'b0, (r == 1) ? 3 : 50);
          check_normal(r, cs, tgt, w[0]);
          r++;
        end
    a0 = err_count;
    repeat (10) @(negedge clk);
    chk(done && err_count == 4'(a0), "R14 done and count held", err_count, a0);

    run_flow(20, 2, 0, 1'b0, 1'b1, 5);
    chk(done && timed_out && !busy, "R13 gating hang times out", {done, timed_out}, 2'b11);
    chk(n_gc0_rd == 14, "R13 gating poll stops at limit", n_gc0_rd, 14);
    chk(mem0[3] == 32'h0000_C000, "R13 no restore after timeout", mem0[3], 32'hC000);
    a0 = n_acc;
    repeat (20) @(negedge clk);
    chk(n_acc == a0 && !req_valid, "R13 no access after timeout", n_acc, a0);

    run_flow(21, 2, 0, 1'b0, 1'b0, 2);
    chk(done && timed_out, "R13 limit 2 aborts on FIFO poll", {done, timed_out}, 2'b11);
    chk(n_gc0_rd == 3, "R13 limit 2 read count", n_gc0_rd, 3);
    chk(err_count == 0, "R14 count cleared on new start", err_count, 0);

    chk(viol == 0, "R2 request held until accepted, none while idle", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule